// File: doc/BRIEF.md
# In-Order I/O Target Response Generator

This block sits on the target side of a packet endpoint. It takes request packets from a header-first stream, where the first beat of each packet is a 64-bit header and any later beats are payload. It decides from the format type and transaction type in that header whether the request needs a reply. If it does, the block queues a small descriptor. A separate output stage turns each queued descriptor into a response packet: a header beat, followed by data beats when the request was a read.

Only write-with-response requests and read requests are answered. Stream writes, plain writes and every other type are consumed and dropped. Responses leave in exactly the order their requests arrived. Each response carries the priority of its request plus one, held at the top value. Read data follows an incrementing byte pattern. When the descriptor queue is full, the request port stalls.

Top module: `io_target_responder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request header with type bits [55:52]=0x5 and [51:48]=0x5 gives a one-beat response with `rsp_last`=1. That beat is a header with [63:56] equal to the request's ID, [55:52]=0xD, [51:48]=0x0, status [43:40]=0, bit 47, bit 44 and bits [39:0] zero.
- R3: A request header with [55:52]=0x2 and [51:48]=0x4 gives a response header with [51:48]=0x8 and `rsp_last`=0. The other header fields are as in R2. Then N+1 data beats follow, where N is request bits [35:32], and `rsp_last`=1 only on the final one.
- R4: Data beat i (counting from 0) of a read response carries byte value 8*i+b in byte lane b, where lane b is bits [8b+7:8b].
- R5: The response priority [46:45] is the request priority [46:45] plus one, held at 3 when the request priority is already 3.
- R6: Requests with [55:52]=0x6 (stream write), [55:52]=0x5 with [51:48]=0x4 (plain write), or any other type pair produce no response beat.
- R7: Response packets leave in the order their requests were accepted. A dropped request does not shift the order.
- R8: Only the first beat after reset or after a beat with `req_last`=1 is decoded as a header. Payload beats are never decoded, even when their bits look like a read header.
- R9: With FIFO_DEPTH (default 4) responses pending and the output stalled, `req_ready` is 0. Nothing that was accepted is lost.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Request beat accepted when high with req_valid |
| req_data | input | 64 | Request beat: header on the first beat, payload after |
| req_last | input | 1 | Final beat of the request packet |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Downstream can take a response beat |
| rsp_data | output | 64 | Response header or data beat |
| rsp_last | output | 1 | Final beat of the response packet |

## Verification
The bench goes after type pairs that sit next to the answered ones. A plain write differs from a write-with-response only in the transaction type. A design that decoded the format type alone would answer the plain write and add an unexpected packet. Some requests carry payload beats shaped like a large read header; a design that lost track of packet boundaries would emit a long run of read data. Priority 3 checks the saturation, since a design that wraps would send priority 0. The output is then stalled until the queue fills. A design that did not stall intake would drop or overwrite a descriptor, and the drained order would show it. A design that let the output change during the stall would show a header that moved.

// File: rtl/rgen_pkg.sv
package rgen_pkg;
  localparam int DATA_W = 64;

  // request header fields
  localparam int TID_HI  = 63;
  localparam int TID_LO  = 56;
  localparam int FT_HI   = 55;
  localparam int FT_LO   = 52;
  localparam int TT_HI   = 51;
  localparam int TT_LO   = 48;
  localparam int PRI_HI  = 46;
  localparam int PRI_LO  = 45;
  localparam int SZ_HI   = 35;
  localparam int SZ_LO   = 32;

  localparam logic [3:0] FT_WRITE    = 4'h5;
  localparam logic [3:0] TT_WRITE_R  = 4'h5;
  localparam logic [3:0] FT_READ     = 4'h2;
  localparam logic [3:0] TT_READ     = 4'h4;
  localparam logic [3:0] FT_RESP     = 4'hD;
  localparam logic [3:0] TT_NODATA   = 4'h0;
  localparam logic [3:0] TT_WITHDATA = 4'h8;
  localparam logic [3:0] ST_DONE     = 4'h0;
  localparam logic [1:0] PRI_MAX     = 2'd3;

  typedef struct packed {
    logic [7:0] tid;
    logic       is_read;
    logic [1:0] prio;
    logic [3:0] last_idx;
  } resp_desc_t;

  localparam int DESC_W = $bits(resp_desc_t);
endpackage

// File: rtl/rgen_rst_sync.sv
module rgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rgen_intake.sv
module rgen_intake
  import rgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_last,
  input  logic              fifo_full,
  output logic              push,
  output resp_desc_t        push_desc
);
  logic       at_hdr_q, at_hdr_d;
  logic       accept;
  logic [3:0] ft, tt;
  logic       is_wr_r, is_rd;
  logic [1:0] pri_in;
  logic       unused_bits;

  assign unused_bits = ^{req_data[47], req_data[44:36], req_data[31:0]};

  always_comb begin
    req_ready = !fifo_full;
    accept    = req_valid && req_ready;
    ft        = req_data[FT_HI:FT_LO];
    tt        = req_data[TT_HI:TT_LO];
    pri_in    = req_data[PRI_HI:PRI_LO];
    is_wr_r   = (ft == FT_WRITE) && (tt == TT_WRITE_R);
    is_rd     = (ft == FT_READ) && (tt == TT_READ);
    push      = accept && at_hdr_q && (is_wr_r || is_rd);

    push_desc.tid      = req_data[TID_HI:TID_LO];
    push_desc.is_read  = is_rd;
    push_desc.prio     = (pri_in == PRI_MAX) ? PRI_MAX : pri_in + 2'd1;
    push_desc.last_idx = is_rd ? req_data[SZ_HI:SZ_LO] : 4'd0;

    at_hdr_d = at_hdr_q;
    if (accept) at_hdr_d = req_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) at_hdr_q <= 1'b1;
    else        at_hdr_q <= at_hdr_d;
  end
endmodule

// File: rtl/rgen_fifo.sv
module rgen_fifo #(
  parameter int WIDTH = 15,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + AW'(1);
    if (pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + AW'(1);
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign full  = (cnt_q == DEPTH_C);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rgen_emit.sv
module rgen_emit
  import rgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  resp_desc_t        head,
  input  logic              empty,
  output logic              pop,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  localparam int LANES = DATA_W / 8;

  logic              in_data_q, in_data_d;
  logic [3:0]        beat_q, beat_d;
  logic [DATA_W-1:0] hdr_word, pat_word;

  assign hdr_word = {head.tid, FT_RESP,
                     head.is_read ? TT_WITHDATA : TT_NODATA,
                     1'b0, head.prio, 1'b0, ST_DONE, 40'h0};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign pat_word[8*b +: 8] = {1'b0, beat_q, 3'(b)};
  end

  always_comb begin
    in_data_d = in_data_q;
    beat_d    = beat_q;
    pop       = 1'b0;
    if (!in_data_q) begin
      rsp_valid = !empty;
      rsp_data  = hdr_word;
      rsp_last  = !head.is_read;
      if (rsp_valid && rsp_ready) begin
        if (head.is_read) begin
          in_data_d = 1'b1;
          beat_d    = 4'd0;
        end else begin
          pop = 1'b1;
        end
      end
    end else begin
      rsp_valid = 1'b1;
      rsp_data  = pat_word;
      rsp_last  = (beat_q == head.last_idx);
      if (rsp_ready) begin
        if (rsp_last) begin
          pop       = 1'b1;
          in_data_d = 1'b0;
        end else begin
          beat_d = beat_q + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data_q <= 1'b0;
      beat_q    <= '0;
    end else begin
      in_data_q <= in_data_d;
      beat_q    <= beat_d;
    end
  end
endmodule

// File: rtl/io_target_responder.sv
module io_target_responder
  import rgen_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_last,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  logic       rst_sync_n;
  logic       push, pop, full, empty;
  resp_desc_t push_desc, head_desc;
  logic [DESC_W-1:0] head_bits;

  rgen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rgen_intake u_intake (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_data  (req_data),
    .req_last  (req_last),
    .fifo_full (full),
    .push      (push),
    .push_desc (push_desc)
  );

  rgen_fifo #(.WIDTH(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (push),
    .push_data (push_desc),
    .pop       (pop),
    .head      (head_bits),
    .full      (full),
    .empty     (empty)
  );

  assign head_desc = resp_desc_t'(head_bits);

  rgen_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .head      (head_desc),
    .empty     (empty),
    .pop       (pop),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );
endmodule

// File: rtl/rgen_checker.sv
module rgen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_data,
  input logic        rsp_last
);
  logic hdr_phase_q;
  logic unused_bits;

  assign unused_bits = ^{rsp_data[63:56], rsp_data[47], rsp_data[44], rsp_data[39:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hdr_phase_q <= 1'b1;
    else if (rsp_valid && rsp_ready)  hdr_phase_q <= rsp_last;
  end

  // R10: a stalled beat holds still
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));

  // R2: every header beat is a done response
  assert_hdr_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_q && rsp_valid |-> rsp_data[55:52] == 4'hD && rsp_data[43:40] == 4'h0);

  // R2: a no-data response is a single beat
  assert_nodata_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_q && rsp_valid && rsp_data[51:48] == 4'h0 |-> rsp_last);

  // R3: a with-data header is never the last beat
  assert_data_hdr_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_q && rsp_valid && rsp_data[51:48] == 4'h8 |-> !rsp_last);

  // R3: header transaction type is one of the two reply kinds
  assert_hdr_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_q && rsp_valid |-> rsp_data[51:48] == 4'h0 || rsp_data[51:48] == 4'h8);

  // R5: raised priority can never be zero
  assert_prio_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_q && rsp_valid |-> rsp_data[46:45] != 2'd0);
endmodule

bind io_target_responder rgen_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_last  (rsp_last)
);

// File: tb/sim_io_target_responder.sv
module sim_io_target_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_data = '0;
  logic        req_last = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic        rsp_last;

  always #5 clk = ~clk;

  io_target_responder u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // captured output beats
  logic [63:0] cap_d [64];
  logic        cap_l [64];
  int          cap_n = 0;
  // expected output beats
  logic [63:0] exp_d [64];
  logic        exp_l [64];
  string       exp_t [64];
  int          exp_n = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready && cap_n < 64) begin
      cap_d[cap_n] = rsp_data;
      cap_l[cap_n] = rsp_last;
      cap_n++;
    end
  end

  typedef struct packed {
    logic [3:0] ft;
    logic [3:0] tt;
    logic [7:0] tid;
    logic [1:0] prio;
    logic [3:0] size;
    logic [3:0] dbeats;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{4'h5, 4'h5, 8'h36, 2'd1, 4'd0, 4'd1},  // R2 write-with-response, payload beat
    '{4'h6, 4'h0, 8'h11, 2'd0, 4'd0, 4'd2},  // R6 stream write, R8 decoy payload
    '{4'h2, 4'h4, 8'h4C, 2'd2, 4'd1, 4'd0},  // R3 read two beats
    '{4'h5, 4'h4, 8'h38, 2'd0, 4'd0, 4'd1},  // R6 plain write
    '{4'h2, 4'h4, 8'h07, 2'd3, 4'd0, 4'd0},  // R5 saturation on a read
    '{4'h5, 4'h5, 8'hA5, 2'd3, 4'd0, 4'd3},  // R5 saturation, R8 decoys
    '{4'h2, 4'h4, 8'hF0, 2'd0, 4'd3, 4'd0},  // R4 four-beat pattern
    '{4'h8, 4'h0, 8'h08, 2'd0, 4'd0, 4'd0}   // R6 other type
  };

  function automatic logic [63:0] req_hdr(input logic [3:0] ft, input logic [3:0] tt,
                                          input logic [7:0] tid, input logic [1:0] pr,
                                          input logic [3:0] sz);
    return {tid, ft, tt, 1'b0, pr, 5'b0, 4'b0, sz, 32'h0};
  endfunction

  function automatic logic [63:0] rsp_hdr(input logic [7:0] tid, input logic [3:0] tt,
                                          input logic [1:0] pr);
    return {tid, 4'hD, tt, 1'b0, pr, 1'b0, 4'h0, 40'h0};
  endfunction

  function automatic logic [63:0] pattern(input int i);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[8*b +: 8] = 8'(8*i + b);
    return v;
  endfunction

  function automatic logic [1:0] raise(input logic [1:0] p);
    return (p == 2'd3) ? 2'd3 : p + 2'd1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic add_exp(input logic [63:0] d, input logic l, input string tag);
    exp_d[exp_n] = d;
    exp_l[exp_n] = l;
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  task automatic send_beat(input logic [63:0] d, input logic l);
    bit acc;
    req_valid = 1'b1;
    req_data  = d;
    req_last  = l;
    do begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic send_req(input vec_t v);
    bit wr_r, rd;
    send_beat(req_hdr(v.ft, v.tt, v.tid, v.prio, v.size), v.dbeats == 0);
    for (int k = 0; k < int'(v.dbeats); k++)
      send_beat(req_hdr(4'h2, 4'h4, 8'hEE, 2'd0, 4'hF), k == int'(v.dbeats) - 1);
    wr_r = (v.ft == 4'h5) && (v.tt == 4'h5);
    rd   = (v.ft == 4'h2) && (v.tt == 4'h4);
    if (wr_r) add_exp(rsp_hdr(v.tid, 4'h0, raise(v.prio)), 1'b1, "R2/R5 no-data header");
    if (rd) begin
      add_exp(rsp_hdr(v.tid, 4'h8, raise(v.prio)), 1'b0, "R3/R5 data header");
      for (int i = 0; i <= int'(v.size); i++)
        add_exp(pattern(i), i == int'(v.size), "R4 data beat");
    end
  endtask

  task automatic compare_all();
    int m;
    m = (cap_n < exp_n) ? cap_n : exp_n;
    check("R6/R7 beat count", 64'(cap_n), 64'(exp_n));
    for (int i = 0; i < m; i++) begin
      check({exp_t[i], " (R7 order) data"}, cap_d[i], exp_d[i]);
      check({exp_t[i], " last"}, 64'(cap_l[i]), 64'(exp_l[i]));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);
    @(posedge clk);
    #1;

    // table walk, output always ready
    rsp_ready = 1'b1;
    for (int v = 0; v < NV; v++) send_req(VEC[v]);
    repeat (40) @(posedge clk);
    #1;
    compare_all();

    // R9/R10: stall output, fill the queue
    cap_n = 0;
    exp_n = 0;
    rsp_ready = 1'b0;
    for (int k = 0; k < 4; k++)
      send_req('{4'h5, 4'h5, 8'(8'h40 + k), 2'd0, 4'd0, 4'd0});
    @(negedge clk);
    check("R9 req_ready with queue full", 64'(req_ready), 64'd0);
    check("R10 valid while stalled", 64'(rsp_valid), 64'd1);
    held = rsp_data;
    repeat (3) @(negedge clk);
    check("R10 data held while stalled", rsp_data, held);
    check("R10 first pending header", rsp_data, rsp_hdr(8'h40, 4'h0, 2'd1));
    @(posedge clk);
    #1;
    rsp_ready = 1'b1;
    send_req('{4'h2, 4'h4, 8'h44, 2'd1, 4'd0, 4'd0});
    repeat (30) @(posedge clk);
    #1;
    compare_all();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule